// File: doc/BRIEF.md
# Variable-Width Gated Timer/Counter

A single timer/counter channel built from an 8-bit high counter that sits above a low-order stage. The low-order stage has a programmable width of 1 to 8 bits, so the whole count is 9 to 16 bits wide. In timer function the channel advances on ticks from a free-running rate divider. That divider divides the clock by 1 to 16. In counter function it advances on falling edges of an external count pin. Counting is qualified by a run bit. When gate mode is on, counting is also qualified by an external gate pin, which makes the channel suitable for measuring pulse widths. When the full active count wraps from all ones to all zeros, a sticky overflow flag is raised.

Software loads the low and high bytes through byte write strobes that share one data bus. It sets the low-stage width through a configuration strobe, and it clears the flag with a dedicated clear strobe. Run, gate mode, source select and rate select are level inputs. Both external pins pass through a two-flop synchronizer. A pin level that changes before clock edge k is therefore first used by the edge detector after edge k+1. A falling edge of the count pin shows in the count after edge k+2.

Top module: `gated_var_timer`

## Requirements
- R1: After reset, the count bytes and the overflow flag are 0, and the low stage is 5 bits wide (width code 4), so the count is 13 bits.
- R2: With `src_sel`=0, the count advances once every `rate_sel`+1 clocks. Over any window of 40 qualifying clocks with `rate_sel`=3, it advances by exactly 10.
- R3: With `src_sel`=1, the count advances by one for each high-then-low pair of synchronized samples of `cnt_pin`. A fall applied before edge k is counted at edge k+2. A pin held at one level, and any rising edge, add nothing. The pin may toggle as fast as every clock.
- R4: Width code c (0..7) makes bits [c:0] of `cnt_lo` the active low stage. When that stage holds all ones, the next increment clears it and adds one to `cnt_hi`.
- R5: An increment happens only when `run`=1 and either `gate_mode`=0 or the synchronized `gate_pin`=1. Otherwise both bytes hold.
- R6: An increment from `cnt_hi`=0xFF with all active low bits set clears the active count and sets `ovf_flag` on the same edge. From zero, the flag rises after 256 × 2^(c+1) × (`rate_sel`+1) clocks.
- R7: `ovf_flag` stays set until `clr_flag` is asserted. A wrap and a clear in the same cycle leave the flag set.
- R8: A byte write in a cycle suppresses that cycle's increment for both bytes, and the written byte takes `wr_data` on that edge. Raising `run` does not clear the count.
- R9: Bits of `cnt_lo` above the active width are ignored. Their value never changes when or how the carry into `cnt_hi` happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_data | input | 8 | Write data for either byte |
| cfg_we | input | 1 | Load strobe for the low-stage width code |
| cfg_width | input | 3 | Low-stage width code c (width c+1) |
| src_sel | input | 1 | 0 = internal ticks, 1 = count-pin falling edges |
| run | input | 1 | Run enable |
| gate_mode | input | 1 | 1 = counting also needs the gate pin high |
| rate_sel | input | 4 | Rate divider setting (divide by value+1) |
| clr_flag | input | 1 | Clear strobe for the overflow flag |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate pin (asynchronous) |
| cnt_lo | output | 8 | Low byte of the count |
| cnt_hi | output | 8 | High byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest cycle to reach from the ports is the one where a wrap and a flag clear meet on the same edge. To get there, the stimulus preloads 0xFF and an all-ones low stage, keeps `clr_flag` high, and lets exactly one increment through. The three-edge latency of a count-pin fall is also hard to pin down. The stimulus changes the pin at a known falling clock edge and checks after each of the next three edges. A behavioural model compares the count and the flag on every clock. The model keeps the count as one integer, whose width follows the programmed code.

// File: rtl/gvt_pkg.sv
package gvt_pkg;
  localparam int LO_MAX_W  = 8;
  localparam int HI_W      = 8;
  localparam int WSEL_W    = $clog2(LO_MAX_W);
  localparam int RATE_W    = 4;
  localparam int SYNC_LEN  = 2;
  localparam logic [WSEL_W-1:0] WSEL_RST = WSEL_W'(4);

  typedef enum logic {SRC_TICK = 1'b0, SRC_PIN = 1'b1} src_e;

  // Active-bit mask of the low stage for width code wsel (width wsel+1).
  function automatic logic [LO_MAX_W-1:0] low_mask(input logic [WSEL_W-1:0] wsel);
    logic [LO_MAX_W-1:0] m;
    for (int i = 0; i < LO_MAX_W; i++) m[i] = (WSEL_W'(i) <= wsel);
    return m;
  endfunction

  // Increment of the active low bits; inactive bits are carried through untouched.
  function automatic logic [LO_MAX_W-1:0] low_step(input logic [LO_MAX_W-1:0] lo,
                                                   input logic [LO_MAX_W-1:0] mask);
    return (lo & ~mask) | ((lo + LO_MAX_W'(1)) & mask);
  endfunction
endpackage

// File: rtl/gvt_sync.sv
module gvt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gvt_rate_div.sv
module gvt_rate_div #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              tick
);
  logic [RATE_W-1:0] div_q;

  assign tick = (div_q >= rate_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/gvt_edge_qual.sv
module gvt_edge_qual
  import gvt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic gate_s,
  input  src_e src,
  input  logic run,
  input  logic gate_mode,
  input  logic tick,
  output logic fall,
  output logic inc
);
  logic prev_q;
  logic gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  assign fall    = prev_q & ~pin_s;
  assign gate_ok = ~gate_mode | gate_s;
  assign inc     = run & gate_ok & ((src == SRC_PIN) ? fall : tick);
endmodule

// File: rtl/gvt_count_core.sv
module gvt_count_core
  import gvt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  input  logic [LO_MAX_W-1:0] mask,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [LO_MAX_W-1:0] wr_data,
  input  logic                clr_flag,
  output logic [LO_MAX_W-1:0] lo_q,
  output logic [HI_W-1:0]     hi_q,
  output logic                flag_q,
  output logic                apply,
  output logic                wrap
);
  logic lo_full, hi_full, any_wr;

  assign any_wr  = wr_lo | wr_hi;
  assign lo_full = ((lo_q & mask) == mask);
  assign hi_full = &hi_q;
  assign apply   = inc & ~any_wr;
  assign wrap    = apply & lo_full & hi_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (any_wr) begin
      if (wr_lo) lo_q <= wr_data;
      if (wr_hi) hi_q <= HI_W'(wr_data);
    end else if (apply) begin
      lo_q <= low_step(lo_q, mask);
      if (lo_full) hi_q <= hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (clr_flag) flag_q <= 1'b0;
  end
endmodule

// File: rtl/gated_var_timer.sv
module gated_var_timer
  import gvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wr_data,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_width,
  input  logic        src_sel,
  input  logic        run,
  input  logic        gate_mode,
  input  logic [3:0]  rate_sel,
  input  logic        clr_flag,
  input  logic        cnt_pin,
  input  logic        gate_pin,
  output logic [7:0]  cnt_lo,
  output logic [7:0]  cnt_hi,
  output logic        ovf_flag
);
  logic [WSEL_W-1:0]   width_q;
  logic [LO_MAX_W-1:0] act_mask;
  logic [1:0]          pins_s;
  logic                tick, fall_evt, inc_evt, apply_evt, wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      width_q <= WSEL_RST;
    else if (cfg_we) width_q <= cfg_width;
  end

  assign act_mask = low_mask(width_q);

  gvt_sync #(.W(2), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({gate_pin, cnt_pin}), .q(pins_s)
  );

  gvt_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tick(tick)
  );

  gvt_edge_qual u_qual (
    .clk(clk), .rst_n(rst_n), .pin_s(pins_s[0]), .gate_s(pins_s[1]),
    .src(src_e'(src_sel)), .run(run), .gate_mode(gate_mode), .tick(tick),
    .fall(fall_evt), .inc(inc_evt)
  );

  gvt_count_core u_core (
    .clk(clk), .rst_n(rst_n), .inc(inc_evt), .mask(act_mask),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .clr_flag(clr_flag),
    .lo_q(cnt_lo), .hi_q(cnt_hi), .flag_q(ovf_flag),
    .apply(apply_evt), .wrap(wrap_evt)
  );
endmodule

// File: rtl/gvt_props.sv
module gvt_props (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_lo,
  input logic       wr_hi,
  input logic [7:0] wr_data,
  input logic       run,
  input logic       clr_flag,
  input logic [7:0] cnt_lo,
  input logic [7:0] cnt_hi,
  input logic       ovf_flag,
  input logic       inc_evt,
  input logic       wrap_evt
);
  // R8: a high-byte write lands on the next edge
  p_write_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cnt_hi == $past(wr_data));

  // R8: a low-byte write lands on the next edge
  p_write_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> cnt_lo == $past(wr_data));

  // R5: stopped and unwritten means both bytes hold
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

  // R5: the qualified increment never occurs without run
  p_inc_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |-> run);

  // R6: a wrap raises the flag
  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf_flag && cnt_hi == 8'h00));

  // R6: the flag rises only after a wrap
  p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wrap_evt));

  // R7: the flag is sticky without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flag) |=> ovf_flag);

  // R7: a clear without a wrap drops the flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flag && !wrap_evt) |=> !ovf_flag);
endmodule

bind gated_var_timer gvt_props u_props (
  .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
  .run(run), .clr_flag(clr_flag), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .ovf_flag(ovf_flag), .inc_evt(inc_evt), .wrap_evt(wrap_evt)
);

// File: tb/gated_var_timer_bench.sv
`timescale 1ns/1ps
module gated_var_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_lo = 0, wr_hi = 0, cfg_we = 0, src_sel = 0, run = 0, gate_mode = 0;
  logic clr_flag = 0, cnt_pin = 1, gate_pin = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] cfg_width = 0;
  logic [3:0] rate_sel = 0;
  logic [7:0] cnt_lo, cnt_hi;
  logic ovf_flag;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  gated_var_timer u_gated_var_timer (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .cfg_we(cfg_we), .cfg_width(cfg_width), .src_sel(src_sel), .run(run),
    .gate_mode(gate_mode), .rate_sel(rate_sel), .clr_flag(clr_flag),
    .cnt_pin(cnt_pin), .gate_pin(gate_pin), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
    .ovf_flag(ovf_flag)
  );

  // Behavioural reference: whole count as one integer of (c+1)+8 bits.
  int m_hi, m_lo, m_w, m_div, m_flag, m_bits, m_mask, m_val;
  bit ms1, ms2, mp, mg1, mg2, m_tick, m_fall, m_inc, m_wrapped;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_w = 4; m_div = 0; m_flag = 0;
      ms1 = 0; ms2 = 0; mp = 0; mg1 = 0; mg2 = 0;
    end else begin
      m_bits = m_w + 1;
      m_mask = (1 << m_bits) - 1;
      m_tick = (m_div >= int'(rate_sel));
      m_fall = mp && !ms2;
      m_inc = run && (!gate_mode || mg2) && (src_sel ? m_fall : m_tick);
      m_wrapped = 0;
      if (wr_lo || wr_hi) begin
        if (wr_lo) m_lo = wr_data;
        if (wr_hi) m_hi = wr_data;
      end else if (m_inc) begin
        m_val = m_hi * (1 << m_bits) + (m_lo & m_mask) + 1;
        if (m_val == (256 << m_bits)) begin m_val = 0; m_wrapped = 1; end
        m_hi = m_val >> m_bits;
        m_lo = (m_lo & ~m_mask & 255) | (m_val & m_mask);
      end
      if (m_wrapped) m_flag = 1; else if (clr_flag) m_flag = 0;
      m_div = m_tick ? 0 : m_div + 1;
      mp = ms2; ms2 = ms1; ms1 = cnt_pin;
      mg2 = mg1; mg1 = gate_pin;
      if (cfg_we) m_w = cfg_width;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, "model hi", int'(cnt_hi), m_hi);
      chk(phase, "model lo", int'(cnt_lo) & ((1 << (m_w + 1)) - 1), m_lo & ((1 << (m_w + 1)) - 1));
      chk(phase, "model flag", int'(ovf_flag), m_flag);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input bit hi, input logic [7:0] d);
    wr_hi = hi; wr_lo = !hi; wr_data = d;
    step();
    wr_hi = 0; wr_lo = 0;
  endtask

  task automatic set_width(input logic [2:0] c);
    cfg_we = 1; cfg_width = c; step(); cfg_we = 0;
  endtask

  task automatic clear_flag();
    clr_flag = 1; step(); clr_flag = 0;
  endtask

  int n;
  logic [7:0] hold_lo, hold_hi;

  initial begin
    step(4);
    rst_n = 1;
    step();
    chk("R1", "reset hi", int'(cnt_hi), 0);
    chk("R1", "reset lo", int'(cnt_lo), 0);
    chk("R1", "reset flag", int'(ovf_flag), 0);

    // R1 / R4: default 5-bit low stage carries at 0x1F
    phase = "R4";
    wr(0, 8'h1F);
    run = 1; step(); run = 0;
    chk("R1", "13-bit carry hi", int'(cnt_hi), 1);
    chk("R4", "13-bit carry lo", int'(cnt_lo) & 8'h1F, 0);

    // R2: rate divide by 4 over 40 qualifying clocks
    phase = "R2";
    rate_sel = 4'd3; wr(1, 0); wr(0, 0);
    run = 1; step(40); run = 0;
    chk("R2", "ticks in 40 clocks", int'(cnt_lo) & 8'h1F, 10);
    rate_sel = 0; step(2);

    // R5: stopped, then gate low, then gate high
    phase = "R5";
    hold_lo = cnt_lo; hold_hi = cnt_hi;
    step(20);
    chk("R5", "stopped lo", int'(cnt_lo), int'(hold_lo));
    gate_mode = 1; gate_pin = 0; run = 1;
    step(20);
    chk("R5", "gate low lo", int'(cnt_lo), int'(hold_lo));
    chk("R5", "gate low hi", int'(cnt_hi), int'(hold_hi));
    run = 0; wr(0, 0); wr(1, 0);
    run = 1; gate_pin = 1; step(10); run = 0;
    chk("R5", "gate high incs", int'(cnt_lo) & 8'h1F, 8);
    gate_mode = 0; gate_pin = 0;

    // R3: counter function
    phase = "R3";
    src_sel = 1; wr(0, 0); wr(1, 0); step(3);
    run = 1;
    cnt_pin = 0; step(1);
    chk("R3", "latency edge k", int'(cnt_lo) & 8'h1F, 0);
    step(1);
    chk("R3", "latency edge k+1", int'(cnt_lo) & 8'h1F, 0);
    step(1);
    chk("R3", "latency edge k+2", int'(cnt_lo) & 8'h1F, 1);
    for (int i = 0; i < 5; i++) begin cnt_pin = 1; step(1); cnt_pin = 0; step(1); end
    for (int i = 0; i < 3; i++) begin cnt_pin = 1; step(3); cnt_pin = 0; step(3); end
    step(10);
    chk("R3", "fall count", int'(cnt_lo) & 8'h1F, 9);
    cnt_pin = 1; step(12);
    chk("R3", "held/rising no count", int'(cnt_lo) & 8'h1F, 9);
    run = 0; src_sel = 0;

    // R4: width code 0 and 7
    phase = "R4";
    set_width(3'd0); wr(0, 0); wr(1, 0);
    run = 1; step(3); run = 0;
    chk("R4", "1-bit hi", int'(cnt_hi), 1);
    chk("R4", "1-bit lo", int'(cnt_lo) & 1, 1);
    set_width(3'd7); wr(0, 8'hFE); wr(1, 0);
    run = 1; step(2); run = 0;
    chk("R4", "8-bit hi", int'(cnt_hi), 1);
    chk("R4", "8-bit lo", int'(cnt_lo), 0);

    // R9: upper low-byte bits ignored
    phase = "R9";
    set_width(3'd4); wr(0, 8'hFE); wr(1, 0);
    run = 1; step(1);
    chk("R9", "no early carry", int'(cnt_hi), 0);
    step(1); run = 0;
    chk("R9", "carry after 0x1F", int'(cnt_hi), 1);
    chk("R9", "active lo cleared", int'(cnt_lo) & 8'h1F, 0);

    // R8: write wins, run does not clear
    phase = "R8";
    run = 1; step(3);
    hold_lo = cnt_lo;
    wr_hi = 1; wr_data = 8'h55; step(); wr_hi = 0;
    chk("R8", "hi written", int'(cnt_hi), 8'h55);
    chk("R8", "lo not advanced", int'(cnt_lo), int'(hold_lo));
    run = 0; wr(1, 8'h12); wr(0, 8'h03);
    run = 1; step(1);
    chk("R8", "run keeps hi", int'(cnt_hi), 8'h12);
    chk("R8", "run keeps lo", int'(cnt_lo) & 8'h1F, 4);
    run = 0;

    // R6: overflow period with width 0 and divide 1 -> 512 clocks
    phase = "R6";
    clear_flag();
    set_width(3'd0); wr(0, 0); wr(1, 0);
    run = 1; n = 0;
    while (!ovf_flag && n < 3000) begin step(); n++; end
    run = 0;
    chk("R6", "overflow period", n, 512);
    chk("R6", "wrapped hi", int'(cnt_hi), 0);

    // R7: sticky, clear, and set wins over clear
    phase = "R7";
    step(5);
    chk("R7", "sticky", int'(ovf_flag), 1);
    clear_flag();
    chk("R7", "cleared", int'(ovf_flag), 0);
    set_width(3'd4); wr(1, 8'hFF); wr(0, 8'h1F);
    clr_flag = 1; run = 1; step(); run = 0;
    chk("R7", "set wins", int'(ovf_flag), 1);
    step(); clr_flag = 0;
    chk("R7", "clear after", int'(ovf_flag), 0);
    step(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule